// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage In-Order Pipeline

This block is the exception control of a five-stage in-order pipeline. Stage 0 is fetch, 1 is decode, 2 is execute, 3 is memory and 4 is write-back. It keeps its own shadow copy of the pipeline. Each slot holds a valid bit, the instruction's PC, a sticky fault flag and a cause code, and every slot moves one stage per clock. Each stage has detection inputs. A detection marks the instruction that is in that stage during that cycle.

A marked instruction becomes a bubble at once. Every instruction younger than the deepest marked one is squashed, and fetch intake stops. Instructions deeper in the pipeline than the marked one keep moving and commit normally. The mark travels on with the instruction. When the marked instruction reaches write-back it is the oldest live instruction, and the exception is taken there. In that cycle fetch is redirected to a fixed handler vector. The exception PC and the cause are captured at the closing edge of the same cycle.

A branch-kill input drops the two front slots together with any faults they hold. A restart pulse empties the whole shadow pipeline and redirects fetch to the saved exception PC, so the faulting instruction runs again.

Top module: `pex_ctrl`

## Requirements
- R1: After synchronous reset all slots are empty. `commit_o`, `redirect_o` and `fetch_hold_o` are low, `live_o` is all zero, and `epc_o` and `cause_o` are zero.
- R2: An instruction accepted at a clock edge sits in fetch for the following cycle. It then advances one stage per cycle, so it is in write-back four cycles after it entered fetch. Instructions without a fault commit in fetch order, with `commit_o` high and their PC on `wb_pc_o`.
- R3: When several instructions carry faults, only the deepest one (the oldest) raises an exception. This holds whether the faults are detected in the same cycle or at different times. Every younger faulting instruction is squashed and never reports.
- R4: Cause codes are 1 fetch fault (detected in fetch), 2 illegal opcode and 3 privilege (both detected in decode), 4 arithmetic (detected in execute) and 5 memory (detected in memory). For one instruction the first recorded cause is kept and later detections are ignored. Between illegal opcode and privilege in the same cycle, illegal opcode wins.
- R5: A faulting instruction and all younger instructions are bubbles: their `live_o` bit is low and they never commit. While a fault is pending, `fetch_hold_o` is high and fetch inputs are ignored.
- R6: Older instructions drain and commit. The exception is taken in the cycle the faulting instruction occupies write-back, which is four cycles after it entered fetch. In that cycle `redirect_o` is high and `redirect_pc_o` equals `HANDLER_PC`.
- R7: From the cycle after the exception is taken, `epc_o` holds the faulting instruction's own PC and `cause_o` holds its cause code.
- R8: A `br_kill_i` cycle removes the instructions in fetch and decode, together with any faults they carry, so those instructions neither commit nor raise an exception. Deeper instructions are unaffected.
- R9: A `restart_i` cycle drives `redirect_o` high with `redirect_pc_o` equal to `epc_o`. In that cycle nothing commits. Every in-flight instruction and pending fault is cleared, and `epc_o` and `cause_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | An instruction is offered to fetch this cycle |
| fetch_pc_i | input | PC_W | PC of the offered instruction |
| if_ffault_i | input | 1 | Fetch fault on the instruction in fetch |
| id_illegal_i | input | 1 | Illegal opcode on the instruction in decode |
| id_priv_i | input | 1 | Privilege fault on the instruction in decode |
| ex_arith_i | input | 1 | Arithmetic fault on the instruction in execute |
| mem_fault_i | input | 1 | Memory fault on the instruction in memory |
| br_kill_i | input | 1 | Branch resolved against the front two stages |
| restart_i | input | 1 | Restart at the saved exception PC |
| live_o | output | NSTG | Per stage: holds an instruction that may update state |
| commit_o | output | 1 | The write-back instruction commits this cycle |
| wb_pc_o | output | PC_W | PC of the write-back instruction |
| fetch_hold_o | output | 1 | Fetch intake is blocked |
| redirect_o | output | 1 | Fetch must restart at `redirect_pc_o` |
| redirect_pc_o | output | PC_W | Handler vector or saved exception PC |
| epc_o | output | PC_W | Saved exception PC |
| cause_o | output | 3 | Saved cause code |

## Verification
The bench targets these situations:
- A younger decode fault in the same cycle as an older execute fault. A design that picked the shallower stage would save the wrong PC.
- An older memory fault detected one cycle after a younger decode fault was already recorded. A design that kept the first fault it saw would report out of program order.
- One instruction that collects two causes, for example illegal opcode and later memory. A design that let the later cause overwrite the earlier one would report cause 5 instead of 2.
- A fault on the first instruction, with nothing older to drain.
- A branch kill over a faulting decode slot, where a design that leaked the flag would raise a spurious exception.
- A restart while a fault is still in flight, where a design that left the flag in place would take a late exception and commit nothing useful.

Commit order and counts are checked against a rule derived from the requirements. A design that let an older instruction be squashed, or a faulting load commit, would show as a mismatch.

// File: rtl/pex_pkg.sv
`timescale 1ns/1ps
package pex_pkg;

    localparam int NSTG    = 5;
    localparam int CAUSE_W = 3;

    localparam int ST_IF  = 0;
    localparam int ST_ID  = 1;
    localparam int ST_EX  = 2;
    localparam int ST_MEM = 3;
    localparam int ST_WB  = NSTG - 1;

    // Lower code means higher priority within one instruction.
    typedef enum logic [CAUSE_W-1:0] {
        CS_NONE    = 3'd0,
        CS_FETCH   = 3'd1,
        CS_ILLEGAL = 3'd2,
        CS_PRIV    = 3'd3,
        CS_ARITH   = 3'd4,
        CS_MEM     = 3'd5
    } cause_e;

    typedef struct packed {
        logic   v;
        logic   fl;
        cause_e cs;
    } tag_t;

    function automatic cause_e decode_cause(input logic illegal, input logic priv);
        if (illegal)   return CS_ILLEGAL;
        else if (priv) return CS_PRIV;
        else           return CS_NONE;
    endfunction

    // A cause already carried by the instruction suppresses any new one.
    function automatic cause_e keep_first(input tag_t t, input cause_e fresh);
        return t.fl ? t.cs : fresh;
    endfunction

endpackage

// File: rtl/pex_detect.sv
`timescale 1ns/1ps
module pex_detect
    import pex_pkg::*;
#(
    parameter int NS         = NSTG,
    parameter int FRONT_KILL = 2
) (
    input  tag_t   [NS-1:0] tag_i,
    input  cause_e [NS-1:0] det_i,
    input  logic            br_kill_i,
    input  logic            restart_i,
    output tag_t   [NS-1:0] eff_o
);

    for (genvar s = 0; s < NS; s++) begin : g_stage
        localparam bit IN_FRONT = (s < FRONT_KILL);
        logic alive;
        assign alive = tag_i[s].v & ~restart_i & ~(br_kill_i & IN_FRONT);
        always_comb begin
            eff_o[s].v  = alive;
            eff_o[s].fl = alive & (tag_i[s].fl | (det_i[s] != CS_NONE));
            eff_o[s].cs = alive ? keep_first(tag_i[s], det_i[s]) : CS_NONE;
        end
    end

endmodule

// File: rtl/pex_select.sv
`timescale 1ns/1ps
module pex_select
    import pex_pkg::*;
#(
    parameter int NS = NSTG
) (
    input  tag_t [NS-1:0] eff_i,
    output logic [NS-1:0] squash_o,
    output logic          any_o,
    output tag_t [NS-2:0] adv_o
);

    // A slot is squashed when any deeper (older) slot carries a fault.
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int s = NS - 1; s >= 0; s--) begin
            squash_o[s] = acc;
            acc         = acc | eff_i[s].fl;
        end
        any_o = acc;
    end

    for (genvar s = 0; s < NS - 1; s++) begin : g_adv
        always_comb begin
            adv_o[s].v  = eff_i[s].v  & ~squash_o[s];
            adv_o[s].fl = eff_i[s].fl & ~squash_o[s];
            adv_o[s].cs = eff_i[s].cs;
        end
    end

endmodule

// File: rtl/pex_stages.sv
`timescale 1ns/1ps
module pex_stages
    import pex_pkg::*;
#(
    parameter int NS   = NSTG,
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fetch_valid_i,
    input  logic [PC_W-1:0] fetch_pc_i,
    input  logic            accept_i,
    input  tag_t [NS-2:0]   adv_i,
    output tag_t [NS-1:0]   tag_o,
    output logic [PC_W-1:0] pc_wb_o
);

    logic [NS-1:0][PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_o <= '0;
            pc_q  <= '0;
        end else begin
            tag_o[0].v  <= fetch_valid_i & accept_i;
            tag_o[0].fl <= 1'b0;
            tag_o[0].cs <= CS_NONE;
            pc_q[0]     <= fetch_pc_i;
            for (int s = 1; s < NS; s++) begin
                tag_o[s] <= adv_i[s-1];
                pc_q[s]  <= pc_q[s-1];
            end
        end
    end

    assign pc_wb_o = pc_q[NS-1];

    // R5: a blocked intake leaves the fetch slot empty.
    a_r5_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        !accept_i |=> !tag_o[0].v);

    // R3: at most one recorded fault survives each edge.
    a_r3_one_pending: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tag_o[0].fl & tag_o[0].v, tag_o[1].fl & tag_o[1].v,
                  tag_o[2].fl & tag_o[2].v, tag_o[3].fl & tag_o[3].v,
                  tag_o[NS-1].fl & tag_o[NS-1].v}));

    for (genvar s = 1; s < NS; s++) begin : g_chk
        // R4: a carried cause is never replaced while it travels.
        a_r4_cause_kept: assert property (@(posedge clk) disable iff (rst)
            (adv_i[s-1].fl && tag_o[s-1].fl && tag_o[s-1].v)
                |=> tag_o[s].cs == $past(tag_o[s-1].cs));
    end

endmodule

// File: rtl/pex_ctrl.sv
`timescale 1ns/1ps
module pex_ctrl
    import pex_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_valid_i,
    input  logic [PC_W-1:0]    fetch_pc_i,
    input  logic               if_ffault_i,
    input  logic               id_illegal_i,
    input  logic               id_priv_i,
    input  logic               ex_arith_i,
    input  logic               mem_fault_i,
    input  logic               br_kill_i,
    input  logic               restart_i,
    output logic [NSTG-1:0]    live_o,
    output logic               commit_o,
    output logic [PC_W-1:0]    wb_pc_o,
    output logic               fetch_hold_o,
    output logic               redirect_o,
    output logic [PC_W-1:0]    redirect_pc_o,
    output logic [PC_W-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o
);

    tag_t   [NSTG-1:0] tag;
    tag_t   [NSTG-1:0] eff;
    tag_t   [NSTG-2:0] adv;
    cause_e [NSTG-1:0] det;
    logic   [NSTG-1:0] squash;
    logic              any_fault;
    logic              accept;
    logic              take;
    logic [PC_W-1:0]   epc_q;
    cause_e            cause_q;

    always_comb begin
        for (int s = 0; s < NSTG; s++) det[s] = CS_NONE;
        det[ST_IF]  = if_ffault_i ? CS_FETCH : CS_NONE;
        det[ST_ID]  = decode_cause(id_illegal_i, id_priv_i);
        det[ST_EX]  = ex_arith_i  ? CS_ARITH : CS_NONE;
        det[ST_MEM] = mem_fault_i ? CS_MEM   : CS_NONE;
    end

    pex_detect #(.NS(NSTG), .FRONT_KILL(2)) u_detect (
        .tag_i     (tag),
        .det_i     (det),
        .br_kill_i (br_kill_i),
        .restart_i (restart_i),
        .eff_o     (eff)
    );

    pex_select #(.NS(NSTG)) u_select (
        .eff_i    (eff),
        .squash_o (squash),
        .any_o    (any_fault),
        .adv_o    (adv)
    );

    assign accept = ~any_fault & ~restart_i;

    pex_stages #(.NS(NSTG), .PC_W(PC_W)) u_stages (
        .clk           (clk),
        .rst           (rst),
        .fetch_valid_i (fetch_valid_i),
        .fetch_pc_i    (fetch_pc_i),
        .accept_i      (accept),
        .adv_i         (adv),
        .tag_o         (tag),
        .pc_wb_o       (wb_pc_o)
    );

    for (genvar s = 0; s < NSTG; s++) begin : g_live
        assign live_o[s] = eff[s].v & ~eff[s].fl & ~squash[s];
    end

    // The write-back slot is the oldest live instruction: act on its flag.
    assign take          = eff[ST_WB].fl;
    assign commit_o      = eff[ST_WB].v & ~eff[ST_WB].fl;
    assign fetch_hold_o  = any_fault;
    assign redirect_o    = take | restart_i;
    assign redirect_pc_o = restart_i ? epc_q : HANDLER_PC;

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q   <= '0;
            cause_q <= CS_NONE;
        end else if (take) begin
            epc_q   <= wb_pc_o;
            cause_q <= eff[ST_WB].cs;
        end
    end

    assign epc_o   = epc_q;
    assign cause_o = cause_q;

    // R6: committing and taking an exception never coincide.
    a_r6_no_commit_on_take: assert property (@(posedge clk) disable iff (rst)
        !(commit_o && redirect_o));

    // R7: a taken exception leaves a real cause behind.
    a_r7_cause_set: assert property (@(posedge clk) disable iff (rst)
        (redirect_o && !restart_i) |=> cause_o != CS_NONE);

    // R8: killed front slots do not reach decode or execute.
    a_r8_front_gone: assert property (@(posedge clk) disable iff (rst)
        br_kill_i |=> (!tag[ST_ID].v && !tag[ST_EX].v));

    // R9: restart empties every slot.
    a_r9_restart_empties: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (!tag[ST_IF].v && !tag[ST_ID].v && !tag[ST_EX].v &&
                       !tag[ST_MEM].v && !tag[ST_WB].v));

endmodule

// File: tb/pex_ctrl_test.sv
`timescale 1ns/1ps
module pex_ctrl_test;
    import pex_pkg::*;

    localparam int          PC_W = 32;
    localparam logic [31:0] HVEC = 32'h0000_0080;
    localparam int          N    = 10;
    localparam int          NSC  = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b0;
    logic               fetch_valid_i, if_ffault_i, id_illegal_i, id_priv_i;
    logic               ex_arith_i, mem_fault_i, br_kill_i, restart_i;
    logic [PC_W-1:0]    fetch_pc_i;
    logic [NSTG-1:0]    live_o;
    logic               commit_o, fetch_hold_o, redirect_o;
    logic [PC_W-1:0]    wb_pc_o, redirect_pc_o, epc_o;
    logic [CAUSE_W-1:0] cause_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pex_ctrl #(.PC_W(PC_W), .HANDLER_PC(HVEC)) uut (
        .clk(clk), .rst(rst),
        .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
        .if_ffault_i(if_ffault_i), .id_illegal_i(id_illegal_i),
        .id_priv_i(id_priv_i), .ex_arith_i(ex_arith_i),
        .mem_fault_i(mem_fault_i), .br_kill_i(br_kill_i),
        .restart_i(restart_i), .live_o(live_o), .commit_o(commit_o),
        .wb_pc_o(wb_pc_o), .fetch_hold_o(fetch_hold_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .epc_o(epc_o), .cause_o(cause_o)
    );

    // Fault kinds d: 1 fetch, 2 illegal, 3 privilege, 4 arithmetic, 5 memory.
    // ek: index of the instruction expected to trap (0 = none); ec: its cause.
    typedef struct packed {
        logic [7:0] k1; logic [7:0] d1;
        logic [7:0] k2; logic [7:0] d2;
        logic [7:0] brk;
        logic [7:0] ek; logic [7:0] ec;
    } scen_t;

    localparam scen_t TBL [NSC] = '{
        '{8'd5, 8'd4, 8'd0, 8'd0, 8'd0, 8'd5, 8'd4},   // single arithmetic
        '{8'd3, 8'd5, 8'd0, 8'd0, 8'd0, 8'd3, 8'd5},   // single memory
        '{8'd6, 8'd2, 8'd5, 8'd4, 8'd0, 8'd5, 8'd4},   // same cycle, deeper wins
        '{8'd4, 8'd2, 8'd4, 8'd5, 8'd0, 8'd4, 8'd2},   // one instr, first cause kept
        '{8'd7, 8'd1, 8'd8, 8'd4, 8'd0, 8'd7, 8'd1},   // younger fault never seen
        '{8'd5, 8'd2, 8'd4, 8'd5, 8'd0, 8'd4, 8'd5},   // older fault detected later
        '{8'd6, 8'd2, 8'd6, 8'd3, 8'd0, 8'd6, 8'd2},   // illegal beats privilege
        '{8'd6, 8'd2, 8'd0, 8'd0, 8'd7, 8'd0, 8'd0},   // wrong-path fault dropped
        '{8'd1, 8'd1, 8'd0, 8'd0, 8'd0, 8'd1, 8'd1},   // fault on first instr
        '{8'd9, 8'd4, 8'd9, 8'd5, 8'd0, 8'd9, 8'd4}    // arith then memory, same instr
    };

    function automatic logic [31:0] pcof(input int k);
        return 32'h0000_1000 + 32'(4 * k);
    endfunction

    function automatic int stage_of(input int d);
        if (d == 1)      return 0;
        else if (d <= 3) return 1;
        else if (d == 4) return 2;
        else             return 3;
    endfunction

    function automatic bit exp_commit(input scen_t sc, input int k);
        if (sc.ek != 0) return k < int'(sc.ek);
        if (sc.brk != 0 && (k == int'(sc.brk) || k == int'(sc.brk) - 1)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic clear_in();
        fetch_valid_i = 0; fetch_pc_i = '0; if_ffault_i = 0; id_illegal_i = 0;
        id_priv_i = 0; ex_arith_i = 0; mem_fault_i = 0; br_kill_i = 0;
        restart_i = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_in();
        rst = 1;
        @(negedge clk);
        rst = 0;
    endtask

    task automatic set_det(input int d);
        case (d)
            1: if_ffault_i  = 1;
            2: id_illegal_i = 1;
            3: id_priv_i    = 1;
            4: ex_arith_i   = 1;
            5: mem_fault_i  = 1;
            default: ;
        endcase
    endtask

    initial begin
        #(10 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_in();
        do_reset();
        #1;
        chk(commit_o == 0 && redirect_o == 0 && fetch_hold_o == 0,
            "R1 outputs after reset", {commit_o, redirect_o, fetch_hold_o}, 0);
        chk(live_o == '0, "R1 live after reset", 32'(live_o), 0);
        chk(epc_o == 0 && cause_o == 0, "R1 epc/cause after reset", epc_o, 0);

        for (int i = 0; i < NSC; i++) begin
            scen_t sc;
            int ptr, ncommit, nexp, nred, red_m;
            bit stopped;
            string tag_c;
            sc = TBL[i];
            tag_c = (sc.brk != 0) ? "R8 commit" : ((sc.ek != 0) ? "R5 commit" : "R2 commit");
            nexp = 0;
            for (int k = 1; k <= N; k++) if (exp_commit(sc, k)) nexp++;
            ptr = 1; ncommit = 0; nred = 0; red_m = -1; stopped = 0;
            do_reset();
            for (int m = 0; m <= N + 8; m++) begin
                if (m > 0) @(negedge clk);
                clear_in();
                fetch_valid_i = !stopped && (m + 1 <= N);
                fetch_pc_i    = pcof(m + 1);
                if (sc.k1 != 0 && m == int'(sc.k1) + stage_of(int'(sc.d1))) set_det(int'(sc.d1));
                if (sc.k2 != 0 && m == int'(sc.k2) + stage_of(int'(sc.d2))) set_det(int'(sc.d2));
                br_kill_i = (sc.brk != 0) && (m == int'(sc.brk));
                #1;
                if (red_m >= 0 && m == red_m + 1) begin
                    chk(epc_o == pcof(int'(sc.ek)), "R7 epc of faulting instr", epc_o, pcof(int'(sc.ek)));
                    chk(cause_o == sc.ec[2:0], "R4 cause priority", 32'(cause_o), 32'(sc.ec));
                end
                if (commit_o) begin
                    while (ptr <= N && !exp_commit(sc, ptr)) ptr++;
                    chk(ptr <= N && wb_pc_o == pcof(ptr), {tag_c, " order"}, wb_pc_o, pcof(ptr));
                    ptr++;
                    ncommit++;
                end
                if (redirect_o) begin
                    nred++;
                    chk(redirect_pc_o == HVEC, "R6 handler target", redirect_pc_o, HVEC);
                    chk(m == int'(sc.ek) + 4, "R6 take cycle", 32'(m), 32'(int'(sc.ek) + 4));
                    red_m = m;
                    stopped = 1;
                end
            end
            chk(ncommit == nexp, {tag_c, " count"}, 32'(ncommit), 32'(nexp));
            chk(nred == ((sc.ek != 0) ? 1 : 0), "R3 exception count", 32'(nred),
                32'((sc.ek != 0) ? 1 : 0));
        end

        // Restart while a fault is in flight; epc still holds pcof(9).
        begin
            int extra;
            extra = 0;
            for (int m = 0; m <= 14; m++) begin
                @(negedge clk);
                clear_in();
                fetch_valid_i = (m < 6);
                fetch_pc_i    = pcof(m + 1);
                if (m == 5) ex_arith_i = 1;
                if (m == 6) restart_i = 1;
                #1;
                if (m == 5) begin
                    chk(live_o == 5'b11000, "R5 bubbles at fault", 32'(live_o), 32'h18);
                    chk(fetch_hold_o == 1, "R5 fetch hold", 32'(fetch_hold_o), 1);
                end
                if (m == 6) begin
                    chk(redirect_o == 1 && redirect_pc_o == pcof(9), "R9 restart target",
                        redirect_pc_o, pcof(9));
                    chk(commit_o == 0, "R9 no commit on restart", 32'(commit_o), 0);
                end
                if (m > 6 && (commit_o || redirect_o)) extra++;
            end
            chk(extra == 0, "R9 flags cleared", 32'(extra), 0);
            chk(fetch_hold_o == 0 && epc_o == pcof(9) && cause_o == 3'd4,
                "R9 state after restart", epc_o, pcof(9));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule